// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Controller

This block is the digital core of a hot-swap circuit breaker. Two comparator outputs reach it already synchronised to the clock. One reports that the sense-resistor drop is above the slow trip level. The other reports that the drop is above the programmable fast level. From these inputs the block decides when to cut the pass transistor's gate enable and when to raise its active-low fault flag. An upstream sequencer enable is combined into the gate output. While that enable is low, the slow filter and the restart timer are held cleared.

A slow trip needs the over-threshold input to stay high without a break for longer than one of four selectable filter delays. A fast trip acts on the next clock edge. The fast path has its own enable so that it can be switched off completely. Two restart policies are available. In latched mode a fault stays until the breaker reset line has been held low for a minimum width and then released. In retry mode the gate comes back by itself after a fixed off period. While the reset line is low in retry mode, the off period starts again. All times are counted in clock cycles set by parameters.

Top module: `oc_breaker`

## Requirements
- R1: While `rst_n` is low, `gate_en` is 0. After reset release with `up_en` and `brk_rst_n` high, `gate_en` is 1 and `fault_n` is 1.
- R2: With `dly_sel` = 0, 1, 2, 3 selecting limit L = DLY0, DLY1, DLY2, DLY3, `sense_slow` high for L+1 consecutive clock samples trips the breaker. L consecutive samples do not trip it.
- R3: A single low sample of `sense_slow` restarts the filter, so two runs of L high samples separated by one low sample do not trip.
- R4: With `qtrip_en` = 1, one high sample of `sense_quick` while the gate is on trips at that edge. With `qtrip_en` = 0, `sense_quick` has no effect.
- R5: After a trip, `gate_en` is 0 and `fault_n` is 0.
- R6: In latched mode (`mode_cycle` = 0), a fault persists indefinitely until `brk_rst_n` has been low for at least RST_MIN_CYCLES samples and is then sampled high. The gate and the flag recover on that edge.
- R7: A `brk_rst_n` low pulse shorter than RST_MIN_CYCLES samples does not clear a latched fault.
- R8: In retry mode (`mode_cycle` = 1) with `brk_rst_n` high, the fault clears exactly CYC_CYCLES edges after the trip edge. If overcurrent is still present, the breaker trips again.
- R9: In retry mode, while `brk_rst_n` is low the fault cannot clear. It clears CYC_CYCLES edges after `brk_rst_n` returns high.
- R10: `brk_rst_n` low forces `gate_en` to 0 in both modes without setting a fault.
- R11: `up_en` low forces `gate_en` to 0, clears the slow filter, and holds the retry timer at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_en | input | 1 | Upstream sequencer enable |
| sense_slow | input | 1 | Sense drop above the slow trip level |
| sense_quick | input | 1 | Sense drop above the fast trip level |
| qtrip_en | input | 1 | Enables the fast trip path |
| dly_sel | input | 2 | Slow filter delay select |
| mode_cycle | input | 1 | 1 = automatic retry, 0 = latched |
| brk_rst_n | input | 1 | Active-low breaker reset / gate hold |
| gate_en | output | 1 | Pass transistor gate enable |
| fault_n | output | 1 | Active-low breaker fault flag |

## Verification
The hardest state to reach from the ports is a retry-mode restart into an overcurrent that is still present. At that point the gate is on for one cycle and must trip again at once. The stimulus holds `sense_quick` high across the whole off period and samples the single cycle in which `gate_en` rises. It then confirms the fault again on the next cycle. A second hard case is a retry timer that has partly run when the reset line drops. The bench holds the line low for longer than the remaining time, releases it, and checks that the full period runs again from the release.

// File: rtl/oc_breaker.sv
module oc_breaker #(
  parameter int DLY0 = 250,
  parameter int DLY1 = 2500,
  parameter int DLY2 = 7500,
  parameter int DLY3 = 20000,
  parameter int CYC_CYCLES = 125_000_000,
  parameter int RST_MIN_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_en,
  input  logic       sense_slow,
  input  logic       sense_quick,
  input  logic       qtrip_en,
  input  logic [1:0] dly_sel,
  input  logic       mode_cycle,
  input  logic       brk_rst_n,
  output logic       gate_en,
  output logic       fault_n
);
  localparam int M01  = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int M23  = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int DMAX = (M01 > M23) ? M01 : M23;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int CW   = $clog2(CYC_CYCLES);
  localparam int RW   = $clog2(RST_MIN_CYCLES + 1);

  logic [DW-1:0] slow_cnt, lim;
  logic [CW-1:0] cyc_cnt;
  logic [RW-1:0] low_cnt;
  logic          tripped, prev_rst;

  always_comb begin
    case (dly_sel)
      2'd0:    lim = DW'(DLY0);
      2'd1:    lim = DW'(DLY1);
      2'd2:    lim = DW'(DLY2);
      default: lim = DW'(DLY3);
    endcase
  end

  assign gate_en = rst_n & up_en & brk_rst_n & ~tripped;
  assign fault_n = ~tripped;

  wire slow_hit = sense_slow && (slow_cnt == lim);
  wire fast_hit = qtrip_en && sense_quick;
  wire trip_now = gate_en && (slow_hit || fast_hit);
  wire rst_ok   = brk_rst_n && !prev_rst && (low_cnt == RW'(RST_MIN_CYCLES));
  wire cyc_done = cyc_cnt == CW'(CYC_CYCLES - 1);
  wire cyc_run  = tripped && mode_cycle && up_en && brk_rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) slow_cnt <= '0;
    else if (!gate_en || !sense_slow) slow_cnt <= '0;
    else if (slow_cnt != lim) slow_cnt <= slow_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || brk_rst_n) low_cnt <= '0;
    else if (low_cnt != RW'(RST_MIN_CYCLES)) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_rst <= 1'b1;
    else prev_rst <= brk_rst_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cyc_run || cyc_done) cyc_cnt <= '0;
    else cyc_cnt <= cyc_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tripped <= 1'b0;
    else if (trip_now) tripped <= 1'b1;
    else if (tripped && ((!mode_cycle && rst_ok) || (cyc_run && cyc_done)))
      tripped <= 1'b0;
  end
endmodule

// File: rtl/oc_breaker_chk.sv
module oc_breaker_chk (
  input logic clk,
  input logic rst_n,
  input logic up_en,
  input logic sense_quick,
  input logic qtrip_en,
  input logic mode_cycle,
  input logic brk_rst_n,
  input logic gate_en,
  input logic fault_n
);
  // R4
  fast_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && qtrip_en && sense_quick) |=> !fault_n);
  // R5
  trip_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(gate_en));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cycle && !fault_n && brk_rst_n && $past(brk_rst_n)) |=> !fault_n);
  // R9
  retry_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cycle && !fault_n && !brk_rst_n) |=> !fault_n);
  // R11
  retry_upen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cycle && !up_en && !fault_n) |=> !fault_n);
endmodule

bind oc_breaker oc_breaker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up_en(up_en), .sense_quick(sense_quick),
  .qtrip_en(qtrip_en), .mode_cycle(mode_cycle), .brk_rst_n(brk_rst_n),
  .gate_en(gate_en), .fault_n(fault_n)
);

// File: tb/tb_oc_breaker.sv
module tb_oc_breaker;
  localparam int CYC  = 40;
  localparam int RMIN = 10;

  logic clk = 0, rst_n = 0, up_en = 1, sense_slow = 0, sense_quick = 0;
  logic qtrip_en = 1, mode_cycle = 0, brk_rst_n = 1;
  logic [1:0] dly_sel = 0;
  logic gate_en, fault_n;
  int errs = 0, checks = 0;

  oc_breaker #(.DLY0(4), .DLY1(8), .DLY2(12), .DLY3(16),
               .CYC_CYCLES(CYC), .RST_MIN_CYCLES(RMIN)) dut (
    .clk(clk), .rst_n(rst_n), .up_en(up_en), .sense_slow(sense_slow),
    .sense_quick(sense_quick), .qtrip_en(qtrip_en), .dly_sel(dly_sel),
    .mode_cycle(mode_cycle), .brk_rst_n(brk_rst_n),
    .gate_en(gate_en), .fault_n(fault_n));

  always #10 clk = ~clk;

  // {dly_sel, high samples, expect trip}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 6'd4,  1'b0}, {2'd0, 6'd5,  1'b1},
    {2'd1, 6'd8,  1'b0}, {2'd1, 6'd9,  1'b1},
    {2'd2, 6'd12, 1'b0}, {2'd2, 6'd13, 1'b1},
    {2'd3, 6'd16, 1'b0}, {2'd3, 6'd17, 1'b1}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic rst_pulse(input int n);
    brk_rst_n = 0; tick(n); brk_rst_n = 1; tick(1);
  endtask

  task automatic fast_pulse();
    sense_quick = 1; tick(1); sense_quick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(3);
    chk(gate_en, 0, "R1 gate in reset");
    rst_n = 1; tick(1);
    chk(gate_en, 1, "R1 gate after reset");
    chk(fault_n, 1, "R1 flag after reset");

    for (int i = 0; i < 8; i++) begin
      dly_sel = VEC[i][8:7];
      sense_slow = 1; tick(int'(VEC[i][6:1])); sense_slow = 0; tick(2);
      chk(fault_n, !VEC[i][0], $sformatf("R2 vec %0d flag", i));
      chk(gate_en, !VEC[i][0], $sformatf("R5 vec %0d gate", i));
      if (VEC[i][0]) rst_pulse(RMIN);
    end

    dly_sel = 0;
    sense_slow = 1; tick(4); sense_slow = 0; tick(1);
    sense_slow = 1; tick(4); sense_slow = 0; tick(2);
    chk(fault_n, 1, "R3 split run");

    qtrip_en = 0; sense_quick = 1; tick(3); sense_quick = 0;
    chk(fault_n, 1, "R4 fast disabled");
    qtrip_en = 1; fast_pulse();
    chk(fault_n, 0, "R4 fast trip flag");
    chk(gate_en, 0, "R5 fast trip gate");

    tick(CYC + 5);
    chk(fault_n, 0, "R6 latched persists");
    rst_pulse(RMIN - 1);
    chk(fault_n, 0, "R7 short pulse");
    rst_pulse(RMIN);
    chk(fault_n, 1, "R6 cleared flag");
    chk(gate_en, 1, "R6 cleared gate");

    for (int m = 0; m < 2; m++) begin
      mode_cycle = m[0];
      brk_rst_n = 0; tick(2);
      chk(gate_en, 0, "R10 hold gate");
      chk(fault_n, 1, "R10 hold no fault");
      brk_rst_n = 1; tick(1);
      chk(gate_en, 1, "R10 release gate");
    end

    mode_cycle = 1; fast_pulse();
    tick(CYC - 1);
    chk(fault_n, 0, "R8 still off");
    tick(1);
    chk(fault_n, 1, "R8 restart flag");
    chk(gate_en, 1, "R8 restart gate");

    sense_quick = 1; tick(1);
    tick(CYC - 1);
    chk(fault_n, 0, "R8 persist off");
    tick(1);
    chk(gate_en, 1, "R8 retry gate on");
    tick(1);
    chk(fault_n, 0, "R8 retrip");
    sense_quick = 0; tick(CYC);
    chk(fault_n, 1, "R8 recovered");

    fast_pulse(); tick(30);
    brk_rst_n = 0; tick(20);
    chk(fault_n, 0, "R9 held by reset");
    brk_rst_n = 1; tick(CYC - 1);
    chk(fault_n, 0, "R9 full period");
    tick(1);
    chk(fault_n, 1, "R9 restart");

    fast_pulse(); up_en = 0; tick(60);
    chk(fault_n, 0, "R11 timer held");
    up_en = 1; tick(CYC);
    chk(fault_n, 1, "R11 timer resumes");

    mode_cycle = 0; up_en = 0; tick(1);
    chk(gate_en, 0, "R11 gate off");
    up_en = 1; dly_sel = 0;
    sense_slow = 1; tick(4); up_en = 0; tick(1); up_en = 1; tick(4);
    sense_slow = 0; tick(2);
    chk(fault_n, 1, "R11 filter cleared");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule